// File: doc/BRIEF.md
# Event and Cycle Counting Monitor

This block counts clock cycles and two chosen hardware events, so that software can measure how a core behaves. A single 32-bit control word holds everything software can set: the run switch, the counter clears, the prescaled cycle mode, three interrupt enables, three overflow flags and two 8-bit event selectors. The cycle counter and the two event counters are 32 bits wide. Each of the three counters can be read and loaded through a plain strobe-based register port.

Each event counter chooses one line of a 256-wide event pulse vector by its 8-bit code, and it counts every clock in which that line is high. When a counter wraps past its maximum value, its overflow flag is set. The interrupt line is the OR of every flag gated by its enable. Software acknowledges an overflow by writing the flag bit back as 1.

Register addresses on `regAddr`: 0 is the control word, 1 is the cycle counter, 2 is event counter 0 and 3 is event counter 1.

Top module: `evmon_unit`

## Requirements
- R1: After reset, the control word and all three counters read 0, and `irqOut` is low.
- R2: Control bits 7, 11 and 31:28 always read 0. The clear bits 1 and 2 also always read 0.
- R3: With bit 0 (run) set and bit 3 clear, the cycle counter adds 1 on every clock. With run clear, no counter changes except through a load. A control write takes effect from the next clock.
- R4: With run set and bit 3 (slow) set, the cycle counter adds 1 once every 64 clocks.
- R5: Event counter 0 (code in bits 19:12) and event counter 1 (code in bits 27:20) each add 1 on every clock in which run is set and `evtPulse[code]` is high.
- R6: An event counter whose code is 0xFF never increments, even when `evtPulse[255]` is high.
- R7: Writing the control word with bit 1 set zeroes both event counters on that write's clock edge. Writing it with bit 2 set zeroes the cycle counter (and its prescaler).
- R8: A write to address 1, 2 or 3 loads that counter with `regWdata`.
- R9: A counter that wraps from 0xFFFFFFFF to 0 sets its flag. The flags are bit 8 for event counter 0, bit 9 for event counter 1 and bit 10 for the cycle counter.
- R10: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. If an overflow arrives on the same clock as a clear of the same flag, the flag stays set.
- R11: An overflow never clears a flag that is already set, so several flags can be pending together.
- R12: `irqOut` is high when any flag is set together with its enable. The enables are bit 4 for event counter 0, bit 5 for event counter 1 and bit 6 for the cycle counter. `irqOut` stays high until the flag or the enable is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address (0 control, 1 cycle, 2 event 0, 3 event 1) |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr` (combinational) |
| evtPulse | input | 256 | Event pulse lines, one for each event code |
| irqOut | output | 1 | Overflow interrupt |

## Verification
An acknowledge write to the control word can land on the same clock edge as a new overflow of the counter whose flag is being cleared. The bench sets this up by preloading event counter 0 to 0xFFFFFFFF with counting running. It then raises the selected event line during the very write that sets flag bits 8 and 10. Flag 8 must survive because its counter wraps on that edge. Flag 10 must clear because the cycle counter is not wrapping. A further check confirms that a second overflow arriving while another flag is pending leaves both flags set.

// File: rtl/evmon_pkg.sv
package evmon_pkg;
  localparam int CNT_W  = 32;
  localparam int SEL_W  = 8;
  localparam int PRE_W  = 6;
  localparam int N_EVT  = 2;
  localparam int N_CTR  = N_EVT + 1;   // index N_EVT is the cycle counter

  // control word bit positions
  localparam int B_RUN  = 0;
  localparam int B_CLRE = 1;
  localparam int B_CLRC = 2;
  localparam int B_SLOW = 3;
  localparam int B_IE   = 4;
  localparam int B_FLAG = 8;
  localparam int B_SEL0 = 12;

  typedef struct packed {
    logic                        run;
    logic                        slow;
    logic                        clrEvt;
    logic                        clrCyc;
    logic [N_EVT-1:0][SEL_W-1:0] sel;
    logic [N_CTR-1:0]            load;
    logic [CNT_W-1:0]            loadVal;
  } strobe_t;
endpackage

// File: rtl/evmon_ctrl.sv
module evmon_ctrl
  import evmon_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [1:0]       regAddr,
  input  logic [31:0]      regWdata,
  input  logic [N_CTR-1:0] ovf,
  output strobe_t          strb,
  output logic [31:0]      ctrlView,
  output logic             irq
);
  logic                        runQ, slowQ;
  logic [N_CTR-1:0]            ieQ, flagQ, clrMask;
  logic [N_EVT-1:0][SEL_W-1:0] selQ;
  logic                        ctrlWr;

  assign ctrlWr  = regWe && (regAddr == 2'd0);
  assign clrMask = ctrlWr ? regWdata[B_FLAG +: N_CTR] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ  <= 1'b0;
      slowQ <= 1'b0;
      ieQ   <= '0;
      flagQ <= '0;
      selQ  <= '0;
    end else begin
      if (ctrlWr) begin
        runQ  <= regWdata[B_RUN];
        slowQ <= regWdata[B_SLOW];
        ieQ   <= regWdata[B_IE +: N_CTR];
        for (int i = 0; i < N_EVT; i++)
          selQ[i] <= regWdata[B_SEL0 + i*SEL_W +: SEL_W];
      end
      // a fresh overflow wins over a clear arriving on the same edge
      flagQ <= (flagQ & ~clrMask) | ovf;
    end
  end

  always_comb begin
    strb.run     = runQ;
    strb.slow    = slowQ;
    strb.clrEvt  = ctrlWr && regWdata[B_CLRE];
    strb.clrCyc  = ctrlWr && regWdata[B_CLRC];
    strb.sel     = selQ;
    strb.load[0] = regWe && (regAddr == 2'd2);
    strb.load[1] = regWe && (regAddr == 2'd3);
    strb.load[2] = regWe && (regAddr == 2'd1);
    strb.loadVal = regWdata;
  end

  always_comb begin
    ctrlView = '0;
    ctrlView[B_RUN]  = runQ;
    ctrlView[B_SLOW] = slowQ;
    ctrlView[B_IE +: N_CTR]   = ieQ;
    ctrlView[B_FLAG +: N_CTR] = flagQ;
    for (int i = 0; i < N_EVT; i++)
      ctrlView[B_SEL0 + i*SEL_W +: SEL_W] = selQ[i];
  end

  assign irq = |(flagQ & ieQ);
endmodule

// File: rtl/evmon_dpath.sv
module evmon_dpath
  import evmon_pkg::*;
#(
  parameter int NUM_EVT = 1 << SEL_W
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  strobe_t                     strb,
  input  logic [NUM_EVT-1:0]          evtPulse,
  output logic [N_CTR-1:0][CNT_W-1:0] cnt,
  output logic [N_CTR-1:0]            ovf
);
  localparam logic [SEL_W-1:0] UNUSED = '1;

  for (genvar g = 0; g < N_EVT; g++) begin : gEvt
    logic hit;
    assign hit = strb.run && (strb.sel[g] != UNUSED) && evtPulse[strb.sel[g]];
    assign ovf[g] = hit && !strb.load[g] && !strb.clrEvt && (cnt[g] == '1);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              cnt[g] <= '0;
      else if (strb.load[g])  cnt[g] <= strb.loadVal;
      else if (strb.clrEvt)   cnt[g] <= '0;
      else if (hit)           cnt[g] <= cnt[g] + 1'b1;
    end
  end

  logic [PRE_W-1:0] preQ;
  logic             tick;

  assign tick       = strb.run && (!strb.slow || (preQ == '1));
  assign ovf[N_EVT] = tick && !strb.load[N_EVT] && !strb.clrCyc && (cnt[N_EVT] == '1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      preQ <= '0;
    else if (strb.clrCyc)           preQ <= '0;
    else if (strb.run && strb.slow) preQ <= preQ + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   cnt[N_EVT] <= '0;
    else if (strb.load[N_EVT])   cnt[N_EVT] <= strb.loadVal;
    else if (strb.clrCyc)        cnt[N_EVT] <= '0;
    else if (tick)               cnt[N_EVT] <= cnt[N_EVT] + 1'b1;
  end
endmodule

// File: rtl/evmon_unit.sv
module evmon_unit
  import evmon_pkg::*;
#(
  parameter int NUM_EVT = 1 << SEL_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWe,
  input  logic [1:0]         regAddr,
  input  logic [31:0]        regWdata,
  output logic [31:0]        regRdata,
  input  logic [NUM_EVT-1:0] evtPulse,
  output logic               irqOut
);
  strobe_t                     strb;
  logic [N_CTR-1:0]            ovf;
  logic [N_CTR-1:0][CNT_W-1:0] cntView;
  logic [31:0]                 ctrlView;

  evmon_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .ovf(ovf), .strb(strb), .ctrlView(ctrlView),
    .irq(irqOut)
  );

  evmon_dpath #(.NUM_EVT(NUM_EVT)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .evtPulse(evtPulse),
    .cnt(cntView), .ovf(ovf)
  );

  always_comb begin
    unique case (regAddr)
      2'd0:    regRdata = ctrlView;
      2'd1:    regRdata = cntView[2];
      2'd2:    regRdata = cntView[0];
      default: regRdata = cntView[1];
    endcase
  end
endmodule

// File: rtl/evmon_chk.sv
module evmon_chk (
  input logic        clk,
  input logic        rstN,
  input logic        regWe,
  input logic [1:0]  regAddr,
  input logic [31:0] regWdata,
  input logic [31:0] regRdata,
  input logic        irqOut,
  input logic [31:0] ctrlQ,
  input logic [31:0] cyc,
  input logic [31:0] cnt0
);
  AST_RESERVED_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 2'd0) |-> (regRdata[2:1] == 2'b0 && !regRdata[7] && !regRdata[11] && regRdata[31:28] == 4'h0)); // R2

  AST_CYC_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlQ[0] && !regWe) |=> (cyc == $past(cyc))); // R3

  AST_UNUSED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ[19:12] == 8'hFF && !regWe) |=> (cnt0 == $past(cnt0))); // R6

  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (!regWe && cnt0 == 32'hFFFF_FFFF) ##1 (cnt0 == 32'h0) |-> ctrlQ[8]); // R9

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ[10] && !(regWe && regAddr == 2'd0 && regWdata[10])) |=> ctrlQ[10]); // R11

  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !regWe) |=> irqOut); // R12
endmodule

bind evmon_unit evmon_chk u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
  .regWdata(regWdata), .regRdata(regRdata), .irqOut(irqOut),
  .ctrlQ(ctrlView), .cyc(cntView[2]), .cnt0(cntView[0])
);

// File: tb/sim_evmon_unit.sv
`timescale 1ns/1ps
module sim_evmon_unit;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         regWe = 1'b0;
  logic [1:0]   regAddr = 2'd0;
  logic [31:0]  regWdata = '0;
  logic [31:0]  regRdata;
  logic [255:0] evtPulse = '0;
  logic         irqOut;
  int           nChk = 0;
  int           nFail = 0;
  bit           done = 1'b0;

  always #2.5 clk = ~clk;

  evmon_unit u0 (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .evtPulse(evtPulse), .irqOut(irqOut)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #0.5;
    d = regRdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      chk("R1 reset value", v, 32'h0);
    end
    chk("R1 irq after reset", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wr(0, 32'hF000_0886);
    rd(0, v);
    chk("R2 forced-zero and pulse bits", v, 32'h0);
  endtask

  task automatic t_load();
    logic [31:0] v;
    wr(1, 32'h1111_0000);
    wr(2, 32'h0000_ABCD);
    wr(3, 32'h0000_0007);
    rd(1, v); chk("R8 load cycle", v, 32'h1111_0000);
    rd(2, v); chk("R8 load event0", v, 32'h0000_ABCD);
    rd(3, v); chk("R8 load event1", v, 32'h0000_0007);
  endtask

  task automatic t_cycle();
    logic [31:0] v;
    wr(1, 32'h0);
    wr(0, 32'h1);
    repeat (10) @(negedge clk);
    rd(1, v); chk("R3 cycle counting", v, 32'd10);
    wr(0, 32'h0);
    repeat (5) @(negedge clk);
    rd(1, v); chk("R3 cycle frozen", v, 32'd11);
  endtask

  task automatic t_event();
    logic [31:0] v;
    wr(2, 32'h0);
    wr(3, 32'h0);
    wr(0, 32'h0FF0_5001);
    evtPulse[255] = 1'b1;
    for (int i = 0; i < 10; i++) begin
      evtPulse[5] = (i % 2 == 0);
      @(negedge clk);
    end
    evtPulse = '0;
    wr(0, 32'h0);
    rd(2, v); chk("R5 event0 count", v, 32'd5);
    rd(3, v); chk("R6 unused code count", v, 32'd0);
  endtask

  task automatic t_clear();
    logic [31:0] v, c;
    rd(1, c);
    wr(0, 32'h2);
    rd(2, v); chk("R7 event clear", v, 32'h0);
    rd(1, v); chk("R7 cycle untouched by event clear", v, c);
    wr(0, 32'h4);
    rd(1, v); chk("R7 cycle clear", v, 32'h0);
  endtask

  task automatic t_cyc_ovf();
    logic [31:0] v;
    wr(1, 32'hFFFF_FFFE);
    wr(0, 32'h41);
    repeat (2) @(negedge clk);
    rd(0, v); chk("R9 cycle flag", v, 32'h441);
    chk("R12 irq raised", {31'b0, irqOut}, 32'h1);
    wr(0, 32'h40);
    rd(0, v); chk("R10 zero write keeps flag", v, 32'h440);
    chk("R12 irq held", {31'b0, irqOut}, 32'h1);
    wr(0, 32'h400);
    rd(0, v); chk("R10 flag cleared", v, 32'h0);
    chk("R12 irq dropped", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic t_sticky();
    logic [31:0] v;
    wr(2, 32'hFFFF_FFFF);
    wr(1, 32'hFFFF_FFF0);
    wr(0, 32'h0000_5011);
    evtPulse[5] = 1'b1;
    @(negedge clk);
    evtPulse = '0;
    rd(0, v); chk("R9 event0 flag", v, 32'h5111);
    chk("R12 irq from event0", {31'b0, irqOut}, 32'h1);
    repeat (20) @(negedge clk);
    rd(0, v); chk("R11 both flags pending", v, 32'h5511);
  endtask

  task automatic t_race();
    logic [31:0] v;
    wr(0, 32'h0000_5010);
    wr(2, 32'hFFFF_FFFF);
    wr(0, 32'h0000_5001);
    evtPulse[5] = 1'b1;
    wr(0, 32'h0000_5501);
    evtPulse = '0;
    rd(0, v); chk("R10 overflow beats same-edge clear", v, 32'h5101);
    rd(2, v); chk("R9 event0 wrapped", v, 32'h0);
    wr(0, 32'h700);
    rd(0, v); chk("R10 clear all flags", v, 32'h0);
  endtask

  task automatic t_slow();
    logic [31:0] v;
    wr(0, 32'h4);
    wr(0, 32'h9);
    repeat (200) @(negedge clk);
    rd(1, v); chk("R4 prescaled cycle count", v, 32'd3);
    wr(0, 32'h0);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nFail);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask();
    t_load();
    t_cycle();
    t_event();
    t_clear();
    t_cyc_ovf();
    t_sticky();
    t_race();
    t_slow();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule